// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block walks a ring of buffer descriptors kept in a small internal descriptor RAM. Each transfer request is served with the descriptor at the current pointer. If that descriptor is valid, the block hands its byte count and index to an external data mover through a start/done handshake. When the mover reports completion, the block closes the descriptor and moves the pointer on. Whether the valid flag survives the close depends on the descriptor's own continuous-mode flag. A descriptor that is last in its chain raises a chain-done status bit. A descriptor flagged for its own interrupt raises a separate per-descriptor event bit. A request that finds an invalid descriptor raises an error bit instead.

The core reaches the block through two ports. A small register port carries commands, status and the interrupt mask. A direct port reads and writes the descriptor RAM. Two commands exist. Initialise returns the pointer to entry 0 and abandons any transfer in flight. Stop aborts the current transfer. On stop, the mover is told whether to write out its buffered data (memory destination) or discard it (peripheral destination), and the descriptor is then closed.

Top module: `dma_chain_seq`

## Requirements
- R1: When idle, a request (`reqIn`=1) on a descriptor with valid bit (bit 0) set pulses `moverStart` in the same cycle. `moverIndex` equals the pointer and `moverCount` equals descriptor bits [15:8]. From the next cycle the busy bit (bit 15 of register 3) reads 1.
- R2: When a descriptor whose continuous bit (bit 1) is 0 completes, its valid bit is cleared in the RAM. Other fields keep the value they had when the descriptor was accepted.
- R3: When a descriptor whose continuous bit is 1 completes, it is written back with its valid bit still set.
- R4: Normal completion of a descriptor with last bit (bit 2) set sets status bit 0 (chain done).
- R5: Normal completion of a descriptor with interrupt bit (bit 3) set sets status bit 1 (descriptor event), whether or not its last bit is set. Interrupt bit 0 leaves status bit 1 alone.
- R6: After a close, the pointer goes to 0 if the descriptor's wrap bit (bit 4) was set or it was the final RAM entry. Otherwise the pointer advances by one.
- R7: A request on a descriptor whose valid bit is 0 sets status bit 2 (error). It gives no `moverStart`, leaves the pointer unchanged and leaves the block idle.
- R8: Writing bit 1 to register 0 while busy pulses `moverStop` once, with `moverFlush` equal to `moverDestMem`. The next `moverDone` then closes the descriptor (valid bit handled per R2/R3), sets status bit 0 and not bit 1, and advances the pointer per R6.
- R9: Writing bit 1 to register 0 while idle sets status bit 0 and changes nothing else.
- R10: Writing bit 0 to register 0 sets the pointer to 0 and returns the block to idle, leaving status and mask unchanged. A later `moverDone` from the abandoned transfer has no effect.
- R11: Status (register 1) is write-one-to-clear, and mask is register 2. `irq` equals the OR of status bits ANDed with mask bits, and status bits stay set until cleared.
- R12: Requests that arrive while busy are ignored and do not pulse `moverStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 command, 1 status, 2 mask, 3 pointer/busy |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| descWe | input | 1 | Descriptor RAM write strobe |
| descAddr | input | 3 | Descriptor RAM index |
| descWdata | input | 16 | Descriptor write data |
| descRdata | output | 16 | Descriptor read data (combinational) |
| reqIn | input | 1 | Transfer request |
| moverStart | output | 1 | Start pulse to the data mover |
| moverIndex | output | 3 | Index of the descriptor being started |
| moverCount | output | 8 | Byte count of the descriptor being started |
| moverDone | input | 1 | Mover completion pulse |
| moverDestMem | input | 1 | 1 when the destination is memory, 0 for a peripheral |
| moverStop | output | 1 | Abort pulse to the mover |
| moverFlush | output | 1 | With moverStop: 1 writes out buffered data, 0 discards it |
| irq | output | 1 | Interrupt, masked OR of status |

## Verification
The bench runs random descriptor contents, requests, stops, initialise commands, status clears and mask changes against a bench-side model of the ring, and checks the RAM, pointer, status and interrupt after each operation. It targets these corner cases:
- The continuous bit. A design that ignored it would lose reusable descriptors, or leave one-shot descriptors valid.
- A last descriptor that also has its interrupt bit set. A design that tied the two bits together would miss one of the two status bits.
- Stop toward each destination type. A wrong design would flush toward a peripheral, or drop data headed for memory.
- Requests on invalid entries. A wrong design would advance the pointer or start the mover anyway.
- Wrap at the final entry, initialise during a transfer, and repeated requests while busy. Mistakes here show up as a wrong pointer or extra start pulses.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int FLAG_V  = 0;
  localparam int FLAG_CM = 1;
  localparam int FLAG_L  = 2;
  localparam int FLAG_I  = 3;
  localparam int FLAG_W  = 4;

  localparam int STATUS_W = 3;
  localparam int ST_DONE  = 0;
  localparam int ST_EVT   = 1;
  localparam int ST_ERR   = 2;

  localparam logic [1:0] ADDR_CMD    = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_MASK   = 2'd2;
  localparam logic [1:0] ADDR_PTR    = 2'd3;

  localparam int CMD_INIT = 0;
  localparam int CMD_STOP = 1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BUSY  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seqState_e;

  typedef struct packed {
    logic accept;     // latch head descriptor, start mover
    logic reject;     // head descriptor invalid
    logic closeDesc;  // write back descriptor, advance pointer
    logic stopClose;  // close came from a stop
    logic idleStop;   // stop with nothing to abort
    logic ptrReset;   // initialise command
  } seqStrobe_t;
endpackage

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqIn,
  input  logic       headValid,
  input  logic       cmdInit,
  input  logic       cmdStop,
  input  logic       moverDone,
  output seqStrobe_t strb,
  output logic       stopPulse,
  output logic       busy
);
  seqState_e state, stateNext;

  always_comb begin
    strb      = '0;
    stopPulse = 1'b0;
    stateNext = state;
    if (cmdInit) begin
      strb.ptrReset = 1'b1;
      stateNext     = SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (cmdStop) begin
            strb.idleStop = 1'b1;
          end else if (reqIn) begin
            if (headValid) begin
              strb.accept = 1'b1;
              stateNext   = SEQ_BUSY;
            end else begin
              strb.reject = 1'b1;
            end
          end
        end
        SEQ_BUSY: begin
          if (moverDone) begin
            strb.closeDesc = 1'b1;
            strb.idleStop  = cmdStop;
            stateNext      = SEQ_IDLE;
          end else if (cmdStop) begin
            stopPulse = 1'b1;
            stateNext = SEQ_DRAIN;
          end
        end
        SEQ_DRAIN: begin
          if (moverDone) begin
            strb.closeDesc = 1'b1;
            strb.stopClose = 1'b1;
            stateNext      = SEQ_IDLE;
          end
        end
        default: stateNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != SEQ_IDLE);
endmodule

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int COUNT_W = 8,
  parameter int REG_W   = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int DESC_W = COUNT_W + 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic                busy,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic                descWe,
  input  logic [PTR_W-1:0]    descAddr,
  input  logic [DESC_W-1:0]   descWdata,
  output logic [DESC_W-1:0]   descRdata,
  output logic                headValid,
  output logic [COUNT_W-1:0]  headCount,
  output logic [PTR_W-1:0]    ptr,
  output logic [STATUS_W-1:0] statusQ,
  output logic                cmdInit,
  output logic                cmdStop,
  output logic                irq
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DESC_W-1:0]   descRam [DEPTH];
  logic [DESC_W-1:0]   headDesc;
  logic [DESC_W-1:0]   curDesc;
  logic [DESC_W-1:0]   wbDesc;
  logic [PTR_W-1:0]    ptrNext;
  logic [STATUS_W-1:0] maskQ;
  logic [STATUS_W-1:0] statusSet;
  logic [STATUS_W-1:0] statusClr;
  logic                unusedBits;

  assign unusedBits = ^regWdata[REG_W-1:STATUS_W];

  // command decode from the register port
  assign cmdInit = regWe && (regAddr == ADDR_CMD) && regWdata[CMD_INIT];
  assign cmdStop = regWe && (regAddr == ADDR_CMD) && regWdata[CMD_STOP];

  assign headDesc  = descRam[ptr];
  assign headValid = headDesc[FLAG_V];
  assign headCount = headDesc[DESC_W-1 -: COUNT_W];
  assign descRdata = descRam[descAddr];

  // descriptor as written back on close
  always_comb begin
    wbDesc = curDesc;
    if (!curDesc[FLAG_CM]) wbDesc[FLAG_V] = 1'b0;
  end

  assign ptrNext = (curDesc[FLAG_W] || ptr == LAST_IDX) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) descRam[i] <= '0;
    end else if (strb.closeDesc) begin
      descRam[ptr] <= wbDesc;
    end else if (descWe) begin
      descRam[descAddr] <= descWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      curDesc <= '0;
    end else begin
      if (strb.accept) curDesc <= headDesc;
      if (strb.ptrReset)       ptr <= '0;
      else if (strb.closeDesc) ptr <= ptrNext;
    end
  end

  // status set and write-one-to-clear; a set wins over a clear
  always_comb begin
    statusSet = '0;
    statusSet[ST_DONE] = strb.idleStop ||
                         (strb.closeDesc && (strb.stopClose || curDesc[FLAG_L]));
    statusSet[ST_EVT]  = strb.closeDesc && !strb.stopClose && curDesc[FLAG_I];
    statusSet[ST_ERR]  = strb.reject;
    statusClr = (regWe && regAddr == ADDR_STATUS) ? regWdata[STATUS_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~statusClr) | statusSet;
      if (regWe && regAddr == ADDR_MASK) maskQ <= regWdata[STATUS_W-1:0];
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_STATUS: regRdata[STATUS_W-1:0] = statusQ;
      ADDR_MASK:   regRdata[STATUS_W-1:0] = maskQ;
      ADDR_PTR: begin
        regRdata[PTR_W-1:0] = ptr;
        regRdata[REG_W-1]   = busy;
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int COUNT_W = 8,
  parameter int REG_W   = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int DESC_W = COUNT_W + 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic               descWe,
  input  logic [PTR_W-1:0]   descAddr,
  input  logic [DESC_W-1:0]  descWdata,
  output logic [DESC_W-1:0]  descRdata,
  input  logic               reqIn,
  output logic               moverStart,
  output logic [PTR_W-1:0]   moverIndex,
  output logic [COUNT_W-1:0] moverCount,
  input  logic               moverDone,
  input  logic               moverDestMem,
  output logic               moverStop,
  output logic               moverFlush,
  output logic               irq
);
  seqStrobe_t          strb;
  logic                busy;
  logic                headValid;
  logic                cmdInit;
  logic                cmdStop;
  logic [PTR_W-1:0]    ptr;
  logic [STATUS_W-1:0] statusQ;

  dcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .headValid(headValid),
    .cmdInit(cmdInit), .cmdStop(cmdStop), .moverDone(moverDone),
    .strb(strb), .stopPulse(moverStop), .busy(busy)
  );

  dcs_datapath #(.DEPTH(DEPTH), .COUNT_W(COUNT_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .descWe(descWe), .descAddr(descAddr), .descWdata(descWdata), .descRdata(descRdata),
    .headValid(headValid), .headCount(moverCount), .ptr(ptr), .statusQ(statusQ),
    .cmdInit(cmdInit), .cmdStop(cmdStop), .irq(irq)
  );

  assign moverStart = strb.accept;
  assign moverIndex = ptr;
  assign moverFlush = moverStop && moverDestMem;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqIn,
  input logic             regWe,
  input logic             moverStart,
  input logic             moverStop,
  input logic             busy,
  input logic [PTR_W-1:0] ptr,
  input logic             doneQ,
  input logic             errQ,
  input logic             cmdInit,
  input logic             clrDone
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    moverStart && !cmdInit |=> busy);

  // R12
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !moverStart);

  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqIn && !moverStart && !regWe) |=> (ptr == $past(ptr)) && errQ && !busy);

  // R8
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({moverStart, moverStop}));

  // R10
  init_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdInit |=> (ptr == '0) && !busy);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !clrDone) |=> doneQ);
endmodule

bind dma_chain_seq dcs_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWe(regWe),
  .moverStart(moverStart), .moverStop(moverStop), .busy(busy), .ptr(ptr),
  .doneQ(statusQ[0]), .errQ(statusQ[2]), .cmdInit(cmdInit),
  .clrDone(regWe && regAddr == 2'd1 && regWdata[0])
);

// File: tb/dma_chain_seq_tb.sv
module dma_chain_seq_tb;
  localparam int DEPTH = 8;
  localparam int PTR_W = 3;
  localparam int DESC_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic descWe = 1'b0;
  logic [PTR_W-1:0] descAddr = '0;
  logic [DESC_W-1:0] descWdata = '0;
  logic [DESC_W-1:0] descRdata;
  logic reqIn = 1'b0;
  logic moverStart;
  logic [PTR_W-1:0] moverIndex;
  logic [7:0] moverCount;
  logic moverDone = 1'b0;
  logic moverDestMem = 1'b0;
  logic moverStop;
  logic moverFlush;
  logic irq;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  logic [15:0] mDesc [DEPTH];
  logic [2:0]  mPtr;
  logic [2:0]  mStatus;
  logic [2:0]  mMask;

  always #5 clk = ~clk;

  dma_chain_seq u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .descWe(descWe), .descAddr(descAddr), .descWdata(descWdata),
    .descRdata(descRdata), .reqIn(reqIn), .moverStart(moverStart), .moverIndex(moverIndex),
    .moverCount(moverCount), .moverDone(moverDone), .moverDestMem(moverDestMem),
    .moverStop(moverStop), .moverFlush(moverFlush), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] nextPtr(input logic [2:0] p, input logic [15:0] d);
    return (d[4] || p == 3'(DEPTH - 1)) ? 3'd0 : p + 3'd1;
  endfunction

  function automatic logic [15:0] closedDesc(input logic [15:0] d);
    logic [15:0] r = d;
    if (!d[1]) r[0] = 1'b0;
    return r;
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic writeDesc(input int idx, input logic [15:0] d);
    descWe = 1'b1; descAddr = 3'(idx); descWdata = d;
    tick();
    descWe = 1'b0;
    mDesc[idx] = d;
  endtask

  // compares RAM, pointer, busy, status, mask and irq with the model
  task automatic checkAll(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      descAddr = 3'(i); #1;
      chk(req, descRdata, mDesc[i]);
    end
    regAddr = 2'd3; #1;
    chk(req, regRdata, {13'd0, mPtr});
    regAddr = 2'd1; #1;
    chk(req, regRdata, {13'd0, mStatus});
    regAddr = 2'd2; #1;
    chk({req, "/R11"}, regRdata, {13'd0, mMask});
    chk({req, "/R11"}, irq, |(mStatus & mMask));
    @(negedge clk);
  endtask

  // one request; stopMid aborts it with the given destination
  task automatic runRequest(input bit stopMid, input bit destMem, input int delay);
    logic [15:0] d;
    d = mDesc[mPtr];
    moverDestMem = destMem;
    reqIn = 1'b1; #1;
    if (!d[0]) begin
      chk("R7 no start", moverStart, 1'b0);
      tick(); reqIn = 1'b0;
      mStatus[2] = 1'b1;
      return;
    end
    chk("R1 start", moverStart, 1'b1);
    chk("R1 index", moverIndex, mPtr);
    chk("R1 count", moverCount, d[15:8]);
    tick(); reqIn = 1'b0;
    regAddr = 2'd3; #1;
    chk("R1 busy", regRdata[15], 1'b1);
    reqIn = 1'b1; #1;
    chk("R12 ignored", moverStart, 1'b0);
    tick(); reqIn = 1'b0;
    for (int k = 0; k < delay; k++) tick();
    if (stopMid) begin
      regWe = 1'b1; regAddr = 2'd0; regWdata = 16'h0002; #1;
      chk("R8 stop", moverStop, 1'b1);
      chk("R8 flush", moverFlush, destMem);
      tick(); regWe = 1'b0; regWdata = '0; #1;
      chk("R8 single stop", moverStop, 1'b0);
      tick();
    end
    moverDone = 1'b1;
    tick(); moverDone = 1'b0;
    mDesc[mPtr] = closedDesc(d);
    if (stopMid) mStatus[0] = 1'b1;
    else begin
      if (d[2]) mStatus[0] = 1'b1;
      if (d[3]) mStatus[1] = 1'b1;
    end
    mPtr = nextPtr(mPtr, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mDesc[i] = '0;
    mPtr = '0; mStatus = '0; mMask = '0;
    void'($urandom(32'd4242));
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkAll("reset");

    // directed descriptor ring
    writeDesc(0, 16'h050D);  // V L I, count 5
    writeDesc(1, 16'h0903);  // V CM
    writeDesc(2, 16'h0A05);  // V L
    writeDesc(3, 16'h0B09);  // V I
    writeDesc(4, 16'h0C13);  // V CM W
    regWrite(2'd2, 16'h0007); mMask = 3'b111;
    checkAll("setup");

    runRequest(0, 0, 2); checkAll("R2 R4 R5 L+I");
    runRequest(0, 0, 0); checkAll("R3 CM keeps V");
    regWrite(2'd1, 16'h0007); mStatus = '0; checkAll("R11 w1c");
    runRequest(0, 0, 1); checkAll("R4 last only");
    runRequest(0, 0, 1); checkAll("R5 I only");
    runRequest(0, 0, 0); checkAll("R6 wrap bit");
    runRequest(0, 0, 0); checkAll("R7 invalid head");
    regWrite(2'd1, 16'h0007); mStatus = '0;
    regWrite(2'd2, 16'h0002); mMask = 3'b010; checkAll("R11 mask");

    // stop toward memory and peripheral
    writeDesc(0, 16'h0701);
    writeDesc(1, 16'h0809);
    runRequest(1, 1, 2); checkAll("R8 stop memory");
    runRequest(1, 0, 1); checkAll("R8 stop periph");
    regWrite(2'd1, 16'h0001); mStatus[0] = 1'b0;
    regWrite(2'd0, 16'h0002); mStatus[0] = 1'b1; checkAll("R9 idle stop");

    // end of table wraps
    writeDesc(7, 16'h0101);
    regWrite(2'd0, 16'h0001); mPtr = '0;
    for (int i = 0; i < 7; i++) writeDesc(i, 16'h0201 | 16'(i << 8));
    for (int i = 0; i < 8; i++) runRequest(0, 0, 0);
    checkAll("R6 final entry");

    // init during a transfer
    writeDesc(2, 16'h0303);
    regWrite(2'd0, 16'h0001); mPtr = '0;
    writeDesc(0, 16'h0405);
    reqIn = 1'b1; tick(); reqIn = 1'b0;
    regWrite(2'd0, 16'h0001);
    moverDone = 1'b1; tick(); moverDone = 1'b0;
    checkAll("R10 init abandons");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2, 3: runRequest(0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
        4: runRequest(1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
        5: begin
          logic [15:0] d;
          d = 16'($urandom);
          d[7:5] = '0;
          if ($urandom_range(0, 3) != 0) d[0] = 1'b1;
          if ($urandom_range(0, 3) != 0) d[4] = 1'b0;
          writeDesc(int'($urandom_range(0, DEPTH - 1)), d);
        end
        6: begin
          logic [2:0] c;
          c = 3'($urandom);
          regWrite(2'd1, {13'd0, c});
          mStatus = mStatus & ~c;
        end
        7: begin
          logic [2:0] m;
          m = 3'($urandom);
          regWrite(2'd2, {13'd0, m});
          mMask = m;
        end
        8: begin regWrite(2'd0, 16'h0002); mStatus[0] = 1'b1; end
        default: begin regWrite(2'd0, 16'h0001); mPtr = '0; end
      endcase
      checkAll("random R2 R3 R4 R5 R6 R7 R11");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule